// File: doc/BRIEF.md
# Write-Protect Command Gate

This block sits between the byte-load stream that fills a page buffer and the controller that programs the page. The host opens a load window, presents byte loads (address plus data), and closes the window. While the window is open the gate scans the leading loads for two command strings: a three-load arming string and a six-load release string. Loads that form part of a command string still being matched are consumed. All other loads inside the window pass through to the page buffer unchanged.

When the window closes, the gate issues a one-cycle verdict. A persistent protect flag decides it. With the flag clear, every window is allowed to commit. With the flag set, a window commits only if it began with the arming string. Otherwise the verdict still fires, so the downstream controller runs its full busy period and polling behaviour, but the commit enable stays low and the array is left unchanged. The arming string sets the flag and the release string clears it, both at window close.

The reset input models a power interruption. It closes any open window but leaves the flag as it was. Only the separate power-on-default input clears the flag. All command addresses and data values are parameters.

Top module: `swp_guard`

## Requirements
- R1: Asserting por_default clears protect on the next clock edge. A reset through rst_n alone leaves protect unchanged.
- R2: A window whose first three accepted loads equal the arming string (entries 0, 1, 2 in order) sets protect and gives commit_en=1 at its verdict.
- R3: When protect is set and a window lacks the arming prefix (and is not a release window), the verdict still fires with commit_en=0 and protect stays set.
- R4: When protect is set, a window that begins with the arming string gives commit_en=1.
- R5: A window whose first six accepted loads equal the release string clears protect at its verdict and gives commit_en=1.
- R6: A load that extends a command string still being matched is not forwarded (pg_valid=0). Every other accepted load in the window is forwarded with pg_addr/pg_data equal to ld_addr/ld_data.
- R7: A mismatch at any step of a command string ends matching of that string for the window. The mismatching load and all later loads are forwarded as data.
- R8: With protect clear, a window without any command gives commit_en=1 and protect stays clear.
- R9: Loads presented while no window is open (or in a window-start or window-end cycle) are accepted (ld_ready=1), are never forwarded, and do not count toward any command.
- R10: Back-pressure: a load that would be forwarded waits for pg_ready (ld_ready follows pg_ready). A command load, or a load outside a window, is accepted regardless of pg_ready.
- R11: verdict_vld is high for exactly the one cycle after a win_end sampled while a window is open. protect shows the updated flag in that same cycle.
- R12: A command string is recognised only as the leading loads of a window. An arming string that follows a data load does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power interruption); closes the window, keeps the flag |
| por_default | input | 1 | Synchronous clear of the protect flag to its delivered (clear) state |
| win_start | input | 1 | One-cycle pulse opening a load window |
| win_end | input | 1 | One-cycle pulse closing the load window |
| ld_valid | input | 1 | Byte load presented |
| ld_ready | output | 1 | Byte load accepted this cycle |
| ld_addr | input | AW | Load address |
| ld_data | input | DW | Load data |
| pg_valid | output | 1 | Data load forwarded to the page buffer |
| pg_ready | input | 1 | Page buffer can take a load |
| pg_addr | output | AW | Forwarded address |
| pg_data | output | DW | Forwarded data |
| protect | output | 1 | Current protect flag |
| verdict_vld | output | 1 | One-cycle window verdict strobe |
| commit_en | output | 1 | Window may commit (valid with verdict_vld) |

## Verification
The bench builds the gate with 8-bit addresses and data. Its arming and release strings share their first two entries, so a partial match on one string can run alongside a full match on the other. The narrow address space and the small command alphabet make random loads land on command addresses often. Partial matches, mismatches at every step and back-to-back arming and release windows therefore occur in the random phase as well as in the directed cases.

// File: rtl/swp_pkg.sv
`timescale 1ns/1ps
package swp_pkg;
  // Outcome of command matching for one window
  typedef struct packed {
    logic arm_hit;
    logic rel_hit;
  } swp_hits_t;
  localparam int ARM_LEN = 3;
  localparam int REL_LEN = 6;
endpackage

// File: rtl/swp_seq_track.sv
`timescale 1ns/1ps
module swp_seq_track #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int LEN = 3,
  parameter logic [LEN*AW-1:0] ADDRS = '0,
  parameter logic [LEN*DW-1:0] DATAS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          cand,
  output logic          done
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;
  logic          alive;
  logic [AW-1:0] exp_a;
  logic [DW-1:0] exp_d;

  always_comb begin
    exp_a = '0;
    exp_d = '0;
    for (int i = 0; i < LEN; i++) begin
      if (cnt == CW'(i)) begin
        exp_a = ADDRS[i*AW +: AW];
        exp_d = DATAS[i*DW +: DW];
      end
    end
  end

  assign cand = alive && (cnt < CW'(LEN)) && (addr == exp_a) && (data == exp_d);
  assign done = alive && (cnt == CW'(LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive <= 1'b0;
      cnt   <= '0;
    end else if (clr) begin
      alive <= 1'b1;
      cnt   <= '0;
    end else if (step && alive && (cnt < CW'(LEN))) begin
      if (cand) cnt <= cnt + CW'(1);
      else      alive <= 1'b0;
    end
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LEN));
  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr |=> done);
  // R6
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && cand && !clr |=> cnt == $past(cnt) + CW'(1));
endmodule

// File: rtl/swp_flag_ctl.sv
`timescale 1ns/1ps
module swp_flag_ctl
  import swp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      por_default,
  input  logic      close,
  input  swp_hits_t hits,
  output logic      protect,
  output logic      verdict_vld,
  output logic      commit_en
);
  logic flag;

  // Flag survives rst_n; only the power-on default clears it
  always_ff @(posedge clk) begin
    if (por_default) flag <= 1'b0;
    else if (close) begin
      if (hits.rel_hit)      flag <= 1'b0;
      else if (hits.arm_hit) flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_vld <= 1'b0;
      commit_en   <= 1'b0;
    end else begin
      verdict_vld <= close;
      commit_en   <= close && (hits.arm_hit || hits.rel_hit || !flag);
    end
  end

  assign protect = flag;

  // R1
  flag_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (protect != $past(protect)) |-> ($past(close) || $past(por_default)));
  // R11
  verdict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> $past(close));
  // R8
  open_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld && !$past(protect) |-> commit_en);
  // R3
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld && $past(protect) && !$past(hits.arm_hit) && !$past(hits.rel_hit)
    |-> !commit_en);
endmodule

// File: rtl/swp_guard.sv
`timescale 1ns/1ps
module swp_guard
  import swp_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter logic [ARM_LEN*AW-1:0] ARM_ADDR = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [ARM_LEN*DW-1:0] ARM_DATA = {8'hA0, 8'h55, 8'hAA},
  parameter logic [REL_LEN*AW-1:0] REL_ADDR = {15'h5555, 15'h2AAA, 15'h5555,
                                               15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [REL_LEN*DW-1:0] REL_DATA = {8'h20, 8'h55, 8'hAA,
                                               8'h80, 8'h55, 8'hAA}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_default,
  input  logic          win_start,
  input  logic          win_end,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic          pg_valid,
  input  logic          pg_ready,
  output logic [AW-1:0] pg_addr,
  output logic [DW-1:0] pg_data,
  output logic          protect,
  output logic          verdict_vld,
  output logic          commit_en
);
  logic      win_open;
  logic      in_win;
  logic      accept;
  logic      cand_arm, cand_rel;
  logic      is_cmd;
  swp_hits_t hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         win_open <= 1'b0;
    else if (win_start) win_open <= 1'b1;
    else if (win_end)   win_open <= 1'b0;
  end

  assign in_win   = win_open && !win_end && !win_start;
  assign is_cmd   = cand_arm || cand_rel;
  assign ld_ready = !in_win || is_cmd || pg_ready;
  assign accept   = ld_valid && ld_ready && in_win;
  assign pg_valid = ld_valid && in_win && !is_cmd;
  assign pg_addr  = ld_addr;
  assign pg_data  = ld_data;

  swp_seq_track #(
    .AW(AW), .DW(DW), .LEN(ARM_LEN), .ADDRS(ARM_ADDR), .DATAS(ARM_DATA)
  ) arm_trk_i (
    .clk(clk), .rst_n(rst_n), .clr(win_start), .step(accept),
    .addr(ld_addr), .data(ld_data), .cand(cand_arm), .done(hits.arm_hit)
  );

  swp_seq_track #(
    .AW(AW), .DW(DW), .LEN(REL_LEN), .ADDRS(REL_ADDR), .DATAS(REL_DATA)
  ) rel_trk_i (
    .clk(clk), .rst_n(rst_n), .clr(win_start), .step(accept),
    .addr(ld_addr), .data(ld_data), .cand(cand_rel), .done(hits.rel_hit)
  );

  swp_flag_ctl flag_i (
    .clk(clk), .rst_n(rst_n), .por_default(por_default),
    .close(win_end && win_open), .hits(hits),
    .protect(protect), .verdict_vld(verdict_vld), .commit_en(commit_en)
  );

  // R9
  pg_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_valid |-> win_open);
  // R10
  pg_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_valid && !pg_ready |-> !ld_ready);
endmodule

// File: tb/swp_guard_tb_top.sv
`timescale 1ns/1ps
module swp_guard_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_default = 1'b1;
  logic win_start = 1'b0, win_end = 1'b0;
  logic ld_valid = 1'b0, pg_ready = 1'b1;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic ld_ready, pg_valid, protect, verdict_vld, commit_en;
  logic [AW-1:0] pg_addr;
  logic [DW-1:0] pg_data;

  always #2.5 clk = ~clk;

  swp_guard #(
    .AW(AW), .DW(DW),
    .ARM_ADDR({8'h15, 8'h2A, 8'h15}),
    .ARM_DATA({8'hC3, 8'h5A, 8'hA5}),
    .REL_ADDR({8'h15, 8'h2A, 8'h15, 8'h15, 8'h2A, 8'h15}),
    .REL_DATA({8'h3C, 8'h5A, 8'hA5, 8'h81, 8'h5A, 8'hA5})
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .por_default(por_default),
    .win_start(win_start), .win_end(win_end),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .pg_valid(pg_valid), .pg_ready(pg_ready), .pg_addr(pg_addr), .pg_data(pg_data),
    .protect(protect), .verdict_vld(verdict_vld), .commit_en(commit_en)
  );

  int checks = 0, errors = 0, fwd_cnt = 0;
  bit rand_rdy = 0, finished = 0;

  int ua[3] = '{8'h15, 8'h2A, 8'h15};
  int ud[3] = '{8'hA5, 8'h5A, 8'hC3};
  int ra[6] = '{8'h15, 8'h2A, 8'h15, 8'h15, 8'h2A, 8'h15};
  int rd[6] = '{8'hA5, 8'h5A, 8'h81, 8'hA5, 8'h5A, 8'h3C};

  // Behavioural reference state
  bit m_prot = 0, m_open = 0, m_vv = 0, m_ce = 0;
  int qa[$], qd[$];

  function automatic bit seq_next(int sa[], int sd[], int len, int a, int d);
    if (qa.size() >= len) return 0;
    for (int i = 0; i < qa.size(); i++)
      if (qa[i] != sa[i] || qd[i] != sd[i]) return 0;
    return (a == sa[qa.size()]) && (d == sd[qa.size()]);
  endfunction

  function automatic bit seq_full(int sa[], int sd[], int len);
    if (qa.size() < len) return 0;
    for (int i = 0; i < len; i++)
      if (qa[i] != sa[i] || qd[i] != sd[i]) return 0;
    return 1;
  endfunction

  function automatic bit m_cmd();
    return seq_next(ua, ud, 3, int'(ld_addr), int'(ld_data)) ||
           seq_next(ra, rd, 6, int'(ld_addr), int'(ld_data));
  endfunction

  function automatic bit m_inwin();
    return m_open && !win_end && !win_start;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit arm, rel, rdy;
    if (pg_valid && pg_ready) fwd_cnt++;
    if (por_default) m_prot = 0;
    if (!rst_n) begin
      m_open = 0; m_vv = 0; m_ce = 0; qa.delete(); qd.delete();
    end else begin
      rdy = !m_inwin() || m_cmd() || pg_ready;
      m_vv = 0; m_ce = 0;
      if (ld_valid && rdy && m_inwin()) begin
        qa.push_back(int'(ld_addr)); qd.push_back(int'(ld_data));
      end
      if (win_end && m_open) begin
        arm = seq_full(ua, ud, 3);
        rel = seq_full(ra, rd, 6);
        m_vv = 1;
        m_ce = arm || rel || !m_prot;
        if (!por_default) begin
          if (rel) m_prot = 0;
          else if (arm) m_prot = 1;
        end
      end
      if (win_start) begin
        m_open = 1; qa.delete(); qd.delete();
      end else if (win_end) m_open = 0;
    end
  end

  // Compare against the reference on every cycle
  always @(negedge clk) begin
    bit exp_pv, exp_rdy;
    if (rst_n && !por_default && !finished) begin
      exp_pv  = ld_valid && m_inwin() && !m_cmd();
      exp_rdy = !m_inwin() || m_cmd() || pg_ready;
      chk(protect === m_prot, "R1", "model protect", protect, m_prot);
      chk(verdict_vld === m_vv, "R11", "model verdict_vld", verdict_vld, m_vv);
      chk(commit_en === m_ce, "R3", "model commit_en", commit_en, m_ce);
      chk(pg_valid === exp_pv, "R6", "model pg_valid", pg_valid, exp_pv);
      chk(ld_ready === exp_rdy, "R10", "model ld_ready", ld_ready, exp_rdy);
      if (exp_pv)
        chk(pg_addr === ld_addr && pg_data === ld_data, "R6", "forwarded byte",
            {pg_addr, pg_data}, {ld_addr, ld_data});
    end
  end

  task automatic open_win();
    win_start = 1; @(posedge clk); #1; win_start = 0;
  endtask

  task automatic load(int a, int d);
    bit ok;
    ld_valid = 1; ld_addr = AW'(a); ld_data = DW'(d);
    do begin
      if (rand_rdy) pg_ready = 1'($urandom_range(0, 1));
      @(negedge clk); ok = ld_ready;
      @(posedge clk); #1;
    end while (!ok);
    ld_valid = 0;
    if (rand_rdy) pg_ready = 1'($urandom_range(0, 1));
  endtask

  task automatic close_win(bit exp_ce, bit exp_p, string req);
    win_end = 1;
    @(negedge clk);
    chk(verdict_vld === 1'b0, "R11", "verdict early", verdict_vld, 0);
    @(posedge clk); #1; win_end = 0;
    @(negedge clk);
    chk(verdict_vld === 1'b1, "R11", "verdict strobe", verdict_vld, 1);
    chk(commit_en === exp_ce, req, "commit_en", commit_en, exp_ce);
    chk(protect === exp_p, req, "protect", protect, exp_p);
    @(posedge clk); #1;
    chk(verdict_vld === 1'b0, "R11", "verdict one cycle", verdict_vld, 0);
  endtask

  task automatic arm_seq();
    for (int i = 0; i < 3; i++) load(ua[i], ud[i]);
  endtask

  initial begin
    int f0, n, kind;
    repeat (3) @(posedge clk);
    #1; rst_n = 1; @(posedge clk); #1; por_default = 0;
    @(negedge clk);
    chk(protect === 1'b0, "R1", "protect after por", protect, 0);
    chk(verdict_vld === 1'b0 && pg_valid === 1'b0, "R1", "idle outputs", verdict_vld, 0);
    @(posedge clk); #1;

    // R8 plain window, unprotected
    open_win(); f0 = fwd_cnt;
    load(8'h01, 8'h11); load(8'h02, 8'h22); load(8'h15, 8'h00); load(8'h40, 8'h44);
    close_win(1, 0, "R8");
    chk(fwd_cnt - f0 == 4, "R6", "plain forwards", fwd_cnt - f0, 4);

    // R2 arming window
    open_win(); f0 = fwd_cnt;
    arm_seq(); load(8'h03, 8'h33); load(8'h04, 8'h44); load(8'h05, 8'h55);
    close_win(1, 1, "R2");
    chk(fwd_cnt - f0 == 3, "R6", "commands consumed", fwd_cnt - f0, 3);

    // R3 protected, no command
    open_win();
    load(8'h06, 8'h66); load(8'h07, 8'h77);
    close_win(0, 1, "R3");

    // R4 protected, with arming prefix
    open_win(); arm_seq(); load(8'h08, 8'h88);
    close_win(1, 1, "R4");

    // R7 mismatch at step two
    open_win(); f0 = fwd_cnt;
    load(8'h15, 8'hA5); load(8'h2A, 8'h00); load(8'h15, 8'hC3); load(8'h09, 8'h99);
    close_win(0, 1, "R7");
    chk(fwd_cnt - f0 == 3, "R7", "forwards after mismatch", fwd_cnt - f0, 3);

    // R12 arming string after a data load
    open_win(); f0 = fwd_cnt;
    load(8'h0A, 8'hAA); arm_seq();
    close_win(0, 1, "R12");
    chk(fwd_cnt - f0 == 4, "R12", "late string forwarded", fwd_cnt - f0, 4);

    // R1 reset without power-on default keeps the flag
    rst_n = 0; @(posedge clk); #1; rst_n = 1; @(negedge clk);
    chk(protect === 1'b1, "R1", "flag kept over rst_n", protect, 1);
    @(posedge clk); #1;

    // R9 loads outside a window
    f0 = fwd_cnt; pg_ready = 0;
    ld_valid = 1; ld_addr = 8'h15; ld_data = 8'hA5;
    @(negedge clk);
    chk(ld_ready === 1'b1 && pg_valid === 1'b0, "R9", "outside window", {ld_ready, pg_valid}, 2);
    @(posedge clk); #1; ld_addr = 8'h2A; ld_data = 8'h5A; @(posedge clk); #1;
    ld_valid = 0; pg_ready = 1;
    open_win(); load(8'h15, 8'hC3);
    close_win(0, 1, "R9");
    chk(fwd_cnt == f0 + 1, "R9", "outside loads dropped", fwd_cnt - f0, 1);

    // R10 back-pressure: data stalls, command passes
    open_win(); pg_ready = 0;
    ld_valid = 1; ld_addr = 8'h15; ld_data = 8'hA5; @(negedge clk);
    chk(ld_ready === 1'b1, "R10", "command ignores pg_ready", ld_ready, 1);
    @(posedge clk); #1; ld_addr = 8'h77; ld_data = 8'h01; @(negedge clk);
    chk(ld_ready === 1'b0, "R10", "data stalls", ld_ready, 0);
    @(posedge clk); #1; pg_ready = 1; @(negedge clk);
    chk(ld_ready === 1'b1 && pg_valid === 1'b1, "R10", "data released", {ld_ready, pg_valid}, 3);
    @(posedge clk); #1; ld_valid = 0;
    close_win(0, 1, "R10");

    // R5 release string
    open_win(); f0 = fwd_cnt;
    for (int i = 0; i < 6; i++) load(ra[i], rd[i]);
    close_win(1, 0, "R5");
    chk(fwd_cnt == f0, "R5", "release consumed", fwd_cnt - f0, 0);

    // Random windows against the reference (R6, R7, R10)
    rand_rdy = 1;
    for (int w = 0; w < 60; w++) begin
      open_win();
      kind = $urandom_range(0, 3);
      n = $urandom_range(0, 4);
      if (kind == 1) arm_seq();
      if (kind == 2) for (int i = 0; i < 6; i++) load(ra[i], rd[i]);
      if (kind == 3) for (int i = 0; i < 2; i++) load(ra[i], rd[i]);
      for (int j = 0; j < n; j++) begin
        int p = $urandom_range(0, 5);
        if ($urandom_range(0, 1) == 1) load(ra[p], rd[p]);
        else load($urandom_range(0, 255), $urandom_range(0, 255));
      end
      win_end = 1; @(posedge clk); #1; win_end = 0; @(posedge clk); #1;
    end
    rand_rdy = 0; pg_ready = 1;

    // R1 power-on default clears
    open_win(); arm_seq(); win_end = 1; @(posedge clk); #1; win_end = 0;
    por_default = 1; @(posedge clk); #1; por_default = 0; @(negedge clk);
    chk(protect === 1'b0, "R1", "por clears flag", protect, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule